// File: doc/BRIEF.md
# Host Command Mailbox

This block is a single 64-bit mailbox that target software writes to send requests to a host-side agent. The word can be written whole with one 8-byte store, or built from two 4-byte stores: one at the base address for the low half and one at base+4 for the high half. Reads return the whole word or one half, depending on the same address and width rules.

Every successful write is decoded in the same cycle. The decoder looks at the word as it stands after the write, including after a half merge. The top byte selects a device, the next byte a command, and the lower 48 bits carry a payload. The exit device latches a sticky completion flag and a status value taken from the payload. The console device sends a character out with a single-cycle strobe. An access the mailbox cannot serve raises a one-cycle fault flag instead.

Top module: `hm_mailbox`

## Requirements
- R1: After reset the word is zero and `exit_done`, `exit_code`, `con_valid`, `acc_fault` and `rd_data` are all zero.
- R2: An 8-byte write (`acc_size`=3) at the base address replaces the whole word. An 8-byte read at the base returns the whole word on `rd_data` one clock after the access.
- R3: A 4-byte write (`acc_size`=2) at the base replaces bits 31..0 only. A 4-byte write at base+4 replaces bits 63..32 only.
- R4: A 4-byte read at the base returns bits 31..0 and a 4-byte read at base+4 returns bits 63..32. In both cases the value appears in `rd_data[31:0]` with the upper bits zero.
- R5: A 1-byte write (`acc_size`=0) or 2-byte write (`acc_size`=1) at the base replaces the whole word with the write data zero-extended from that width.
- R6: A write at base+4 of any size other than 4 bytes, or a write to any address other than base or base+4, raises `acc_fault` for one cycle and leaves the word unchanged.
- R7: A read other than an 8-byte read at the base or a 4-byte read at the base or at base+4 raises `acc_fault` for one cycle. Any cycle without a successful read leaves `rd_data` at zero.
- R8: After a write, if bits 63..56 of the word are 0x00 and bit 0 of the payload (word bit 0) is 1, `exit_done` rises and `exit_code` becomes the 48-bit payload (bits 47..0) shifted right by one, zero-extended to 64 bits.
- R9: A write that leaves device 0x00 with payload bit 0 equal to 0 changes neither `exit_done` nor `exit_code`.
- R10: Once set, `exit_done` stays set until reset, and `exit_code` keeps its value even if a later write carries another exit request.
- R11: After a write that leaves device 0x01 with command (bits 55..48) 0x01, `con_valid` is high for exactly one cycle and `con_char` carries word bits 7..0. Any other command on that device gives no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | 2 | log2 of the access width in bytes |
| acc_wdata | input | 64 | Write data, right-aligned |
| rd_data | output | 64 | Read result, registered |
| acc_fault | output | 1 | One-cycle fault for an unserved access |
| exit_done | output | 1 | Sticky completion flag |
| exit_code | output | 64 | Status latched with completion |
| con_valid | output | 1 | One-cycle console character strobe |
| con_char | output | 8 | Console character |

## Verification
The assertions assume that an access lasts exactly one cycle, with `acc_valid` high for that cycle only. They also assume that inputs change only away from the clock edge. Under those assumptions, each registered flag can be traced to the access that came just before it. The bench drives every access on the falling edge and drops `acc_valid` on the next falling edge, so it always stays inside these rules. The sweep uses data whose device byte is neither 0x00 nor 0x01, and whose low bit is zero. This keeps the exit and console paths quiet until the directed cases that are meant to trigger them.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int WORD_W  = 64;
  localparam int HALF_W  = WORD_W / 2;
  localparam int DEV_LSB = 56;
  localparam int CMD_LSB = 48;
  localparam int PAY_W   = 48;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  function automatic logic [7:0] dev_of(input logic [WORD_W-1:0] w);
    return w[DEV_LSB +: 8];
  endfunction

  function automatic logic [7:0] cmd_of(input logic [WORD_W-1:0] w);
    return w[CMD_LSB +: 8];
  endfunction

  function automatic logic [PAY_W-1:0] pay_of(input logic [WORD_W-1:0] w);
    return w[PAY_W-1:0];
  endfunction
endpackage

// File: rtl/hm_access.sv
module hm_access
  import hm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [WORD_W-1:0] acc_wdata,
  input  logic [WORD_W-1:0] cur_word,
  output logic              upd,
  output logic [WORD_W-1:0] next_word,
  output logic              rd_ok,
  output logic [WORD_W-1:0] rd_val,
  output logic              fault
);
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(4);
  localparam int NBYTES = WORD_W / 8;

  logic             at_lo, at_hi;
  logic [WORD_W-1:0] wmask;

  assign at_lo = (acc_addr == BASE_ADDR);
  assign at_hi = (acc_addr == HI_ADDR);

  // byte lane mask for a zero-extended narrow write
  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign wmask[b*8 +: 8] = (b < (32'd1 << acc_size)) ? 8'hFF : 8'h00;
  end

  always_comb begin
    upd       = 1'b0;
    next_word = cur_word;
    rd_ok     = 1'b0;
    rd_val    = '0;
    fault     = 1'b0;
    if (acc_valid) begin
      if (acc_write) begin
        if (at_lo) begin
          upd = 1'b1;
          if (acc_size == SZ_WORD)
            next_word = {cur_word[WORD_W-1:HALF_W], acc_wdata[HALF_W-1:0]};
          else
            next_word = acc_wdata & wmask;
        end else if (at_hi && acc_size == SZ_WORD) begin
          upd       = 1'b1;
          next_word = {acc_wdata[HALF_W-1:0], cur_word[HALF_W-1:0]};
        end else begin
          fault = 1'b1;
        end
      end else begin
        if (at_lo && acc_size == SZ_DWORD) begin
          rd_ok  = 1'b1;
          rd_val = cur_word;
        end else if (at_lo && acc_size == SZ_WORD) begin
          rd_ok  = 1'b1;
          rd_val = {{HALF_W{1'b0}}, cur_word[HALF_W-1:0]};
        end else if (at_hi && acc_size == SZ_WORD) begin
          rd_ok  = 1'b1;
          rd_val = {{HALF_W{1'b0}}, cur_word[WORD_W-1:HALF_W]};
        end else begin
          fault = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hm_cmd_decode.sv
module hm_cmd_decode
  import hm_pkg::*;
#(
  parameter logic [7:0] DEV_EXIT = 8'h00,
  parameter logic [7:0] DEV_CON  = 8'h01,
  parameter logic [7:0] CMD_PUT  = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [WORD_W-1:0] word,
  output logic              exit_done,
  output logic [WORD_W-1:0] exit_code,
  output logic              con_valid,
  output logic [7:0]        con_char
);
  logic [PAY_W-1:0] pay;
  logic             is_exit, is_put;

  assign pay     = pay_of(word);
  assign is_exit = fire && dev_of(word) == DEV_EXIT && pay[0];
  assign is_put  = fire && dev_of(word) == DEV_CON && cmd_of(word) == CMD_PUT;

  always_ff @(posedge clk) begin
    if (rst) begin
      exit_done <= 1'b0;
      exit_code <= '0;
      con_valid <= 1'b0;
      con_char  <= '0;
    end else begin
      con_valid <= is_put;
      if (is_put) con_char <= pay[7:0];
      if (is_exit && !exit_done) begin
        exit_done <= 1'b1;
        exit_code <= WORD_W'(pay >> 1);
      end
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    exit_done |=> exit_done); // R10
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    exit_done |=> $stable(exit_code)); // R10
  AST_CON_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    con_valid |-> $past(fire)); // R11
  AST_DONE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(exit_done) |-> $past(fire)); // R8
endmodule

// File: rtl/hm_mailbox.sv
module hm_mailbox
  import hm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [63:0]       acc_wdata,
  output logic [63:0]       rd_data,
  output logic              acc_fault,
  output logic              exit_done,
  output logic [63:0]       exit_code,
  output logic              con_valid,
  output logic [7:0]        con_char
);
  logic [WORD_W-1:0] word_q, next_word, rd_val;
  logic              upd, rd_ok, fault;

  hm_access #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_access (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .cur_word  (word_q),
    .upd       (upd),
    .next_word (next_word),
    .rd_ok     (rd_ok),
    .rd_val    (rd_val),
    .fault     (fault)
  );

  // decoder sees the merged word, not the raw write data
  hm_cmd_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .fire      (upd),
    .word      (next_word),
    .exit_done (exit_done),
    .exit_code (exit_code),
    .con_valid (con_valid),
    .con_char  (con_char)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      rd_data   <= '0;
      acc_fault <= 1'b0;
    end else begin
      if (upd) word_q <= next_word;
      rd_data   <= rd_ok ? rd_val : '0;
      acc_fault <= fault;
    end
  end

  AST_FAULT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    acc_fault |-> $past(acc_valid)); // R6
  AST_FAULT_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
    (acc_fault && $past(acc_write)) |-> $stable(word_q)); // R6
  AST_READ_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_valid && acc_write) |-> $stable(word_q)); // R2
  AST_RD_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_data != '0) |-> $past(acc_valid && !acc_write)); // R7
endmodule

// File: tb/hm_mailbox_bench.sv
module hm_mailbox_bench;
  localparam int ADDR_W = 16;
  localparam logic [15:0] BASE = 16'h1000;

  logic clk = 1'b0, rst = 1'b1;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] rd_data, exit_code;
  logic acc_fault, exit_done, con_valid;
  logic [7:0] con_char;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hm_mailbox #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE)) u_hm_mailbox (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .acc_fault(acc_fault), .exit_done(exit_done),
    .exit_code(exit_code), .con_valid(con_valid), .con_char(con_char));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle access; returns at the falling edge after the capturing edge
  task automatic acc(input bit wr, input logic [15:0] a, input logic [1:0] sz, input logic [63:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    report();
  end

  initial begin
    logic [63:0] P, D, exp_w, exp_rd, mask;
    logic [15:0] a;
    bit exp_f;
    P = 64'h5533_7711_2468_ACE2;
    D = 64'hA5C3_7E12_9B46_D8F0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 64'd0);
    check("R1 acc_fault", {63'd0, acc_fault}, 64'd0);
    check("R1 exit_done", {63'd0, exit_done}, 64'd0);
    check("R1 exit_code", exit_code, 64'd0);
    check("R1 con_valid", {63'd0, con_valid}, 64'd0);
    acc(1'b0, BASE, 2'd3, 64'd0);
    check("R1 word zero", rd_data, 64'd0);

    // sweep: op x address x size
    for (int wr = 0; wr < 2; wr++)
      for (int off = 0; off < 4; off++)
        for (int sz = 0; sz < 4; sz++) begin
          a = BASE + 16'(off * 4) - 16'd4;
          acc(1'b1, BASE, 2'd3, P);
          mask = (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
          exp_w = P; exp_rd = '0; exp_f = 1'b0;
          if (wr == 1) begin
            if (off == 1 && sz == 3)      exp_w = D;
            else if (off == 1 && sz == 2) exp_w = {P[63:32], D[31:0]};
            else if (off == 1)            exp_w = D & mask;
            else if (off == 2 && sz == 2) exp_w = {D[31:0], P[31:0]};
            else                          exp_f = 1'b1;
          end else begin
            if (off == 1 && sz == 3)      exp_rd = P;
            else if (off == 1 && sz == 2) exp_rd = {32'd0, P[31:0]};
            else if (off == 2 && sz == 2) exp_rd = {32'd0, P[63:32]};
            else                          exp_f = 1'b1;
          end
          acc(wr[0], a, 2'(sz), D);
          if (wr == 1) begin
            check(exp_f ? "R6 write fault" : "R3/R5 write ok", {63'd0, acc_fault}, {63'd0, exp_f});
            check("R7 rd_data zero on write", rd_data, 64'd0);
          end else begin
            check(exp_f ? "R7 read fault" : "R4 read ok", {63'd0, acc_fault}, {63'd0, exp_f});
            check("R2/R4/R7 read value", rd_data, exp_rd);
          end
          acc(1'b0, BASE, 2'd3, 64'd0);
          check(exp_f && wr == 1 ? "R6 word unchanged" : "R2/R3/R5 word", rd_data, exp_w);
          check("R6 fault is one cycle", {63'd0, acc_fault}, 64'd0);
        end
    check("R9 no done during sweep", {63'd0, exit_done}, 64'd0);

    // console R11
    acc(1'b1, BASE, 2'd3, 64'h0101_0000_0000_0041);
    check("R11 con_valid", {63'd0, con_valid}, 64'd1);
    check("R11 con_char", {56'd0, con_char}, 64'h41);
    @(negedge clk);
    check("R11 strobe one cycle", {63'd0, con_valid}, 64'd0);
    acc(1'b1, BASE, 2'd3, 64'h0102_0000_0000_0042);
    check("R11 other cmd no strobe", {63'd0, con_valid}, 64'd0);

    // exit device, payload bit0 clear R9
    acc(1'b1, BASE, 2'd3, 64'h0000_0000_0000_0000);
    acc(1'b1, BASE + 16'd4, 2'd2, 64'h0000_1234);
    check("R9 no done", {63'd0, exit_done}, 64'd0);
    check("R9 code unchanged", exit_code, 64'd0);
    // low half completes request R8 (merged word)
    acc(1'b1, BASE, 2'd2, 64'h0000_00AB);
    check("R8 done", {63'd0, exit_done}, 64'd1);
    check("R8 exit code", exit_code, 64'h0000_091A_0000_0055);
    // second request R10
    acc(1'b1, BASE, 2'd3, 64'h0000_0000_0000_0007);
    repeat (3) @(negedge clk);
    check("R10 done sticky", {63'd0, exit_done}, 64'd1);
    check("R10 code held", exit_code, 64'h0000_091A_0000_0055);
    report();
  end
endmodule